// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two page table entries from memory, one after the other. A client presents a virtual address with the frame number of the root table. The walker uses the upper index field of the address to select an entry in the root table. That entry names the frame of a leaf table. The middle index field then selects an entry in the leaf table, and that entry names the frame of the target page. The physical address is the leaf frame number placed above the untouched page offset.

Either table entry may be marked not present. In that case the walk ends at once with a fault flag and no address. The memory side is a plain read port. The walker issues one read, then waits as long as it takes for the matching response. It serves one translation at a time and holds its ready output low until the result has been delivered.

Top module: `pgw_walker`

## Requirements
- R1: With the default widths, the virtual address splits into a root index in bits 31:22, a leaf index in bits 21:12 and a page offset in bits 11:0. The first memory read goes to address root_frame*4096 + root_index*4.
- R2: A page table entry is 32 bits wide. Bit 0 is the present flag and bits 31:12 are the frame number; bits 11:1 are ignored. When the root entry is present, the second read goes to root_entry_frame*4096 + leaf_index*4.
- R3: When both entries are present, the result is {leaf_entry_frame, offset}, and done_fault is 0.
- R4: When the root entry is not present, the walk ends after a single read with done_fault = 1 and done_pa = 0.
- R5: When the root entry is present and the leaf entry is not, the walk ends after two reads with done_fault = 1 and done_pa = 0.
- R6: req_ready is high only while the walker is idle. A req_valid seen while it is busy is ignored and does not change the result in progress.
- R7: done is high for exactly one cycle per accepted request. done_fault and done_pa are 0 whenever done is low. req_ready is high again in the cycle after done.
- R8: mem_req_valid is high for one cycle per read. The walker stays in a read until mem_rsp_valid arrives, whatever the latency.
- R9: Virtual address 0x00403004 yields root index 1, leaf index 3 and offset 4, so it reads root entry 1 and leaf entry 3 and carries offset 4 into the result.
- R10: After reset, req_ready = 1, done = 0 and mem_req_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | VA_W (32) | Virtual address to translate |
| req_root | input | FRAME_W (20) | Frame number of the root table |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | PA_W (32) | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W (32) | Page table entry returned |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Translation faulted (valid with done) |
| done_pa | output | PA_W (32) | Physical address (valid with done) |

## Verification
The bench builds the walker with its default widths: two 10-bit index fields over a 12-bit offset. This keeps the stated example address and the real field boundaries in play. A memory model in the bench computes every entry from its address. The sweep covers all 1024 root indices, plus every leaf index under the first and last root entries. The present patterns in the model make both fault exits occur many times. Response latencies run from zero to seventeen cycles, and requests are driven into the busy walker, so the waiting and ignoring behaviour is exercised along with the address arithmetic.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_state_e;

   function automatic int unsigned clog2_u(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/pgw_va_split.sv
module pgw_va_split #(
   parameter int TOP_W  = 10,
   parameter int LEAF_W = 10,
   parameter int OFS_W  = 12,
   localparam int VA_W  = TOP_W + LEAF_W + OFS_W
) (
   input  logic [VA_W-1:0]   va,
   output logic [TOP_W-1:0]  top_idx,
   output logic [LEAF_W-1:0] leaf_idx,
   output logic [OFS_W-1:0]  page_ofs
);
   assign top_idx  = va[VA_W-1 -: TOP_W];
   assign leaf_idx = va[OFS_W +: LEAF_W];
   assign page_ofs = va[OFS_W-1:0];
endmodule

// File: rtl/pgw_pte_addr.sv
module pgw_pte_addr #(
   parameter int IDX_W     = 10,
   parameter int OFS_W     = 12,
   parameter int FRAME_W   = 20,
   parameter int PTE_SHIFT = 2,
   localparam int PA_W     = FRAME_W + OFS_W,
   localparam int PAD_W    = OFS_W - IDX_W - PTE_SHIFT
) (
   input  logic [FRAME_W-1:0] table_frame,
   input  logic [IDX_W-1:0]   idx,
   output logic [PA_W-1:0]    entry_addr
);
   generate
      if (PAD_W < 0) begin : g_bad_fit
         $error("pgw_pte_addr: table of 2**IDX_W entries does not fit one page");
      end else if (PAD_W == 0) begin : g_tight
         if (PTE_SHIFT == 0) begin : g_noshift
            assign entry_addr = {table_frame, idx};
         end else begin : g_shift
            assign entry_addr = {table_frame, idx, {PTE_SHIFT{1'b0}}};
         end
      end else begin : g_padded
         if (PTE_SHIFT == 0) begin : g_noshift
            assign entry_addr = {table_frame, {PAD_W{1'b0}}, idx};
         end else begin : g_shift
            assign entry_addr = {table_frame, {PAD_W{1'b0}}, idx, {PTE_SHIFT{1'b0}}};
         end
      end
   endgenerate
endmodule

// File: rtl/pgw_pte_decode.sv
module pgw_pte_decode #(
   parameter int PTE_W       = 32,
   parameter int OFS_W       = 12,
   parameter int FRAME_W     = 20,
   parameter int PRESENT_BIT = 0,
   localparam int FLD_W      = PTE_W - OFS_W
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               present,
   output logic [FRAME_W-1:0] frame
);
   if (PRESENT_BIT >= OFS_W) begin : g_bad_flag
      $error("pgw_pte_decode: present flag must sit below the frame field");
   end
   if (FLD_W < 1) begin : g_bad_width
      $error("pgw_pte_decode: entry too narrow to hold a frame field");
   end

   assign present = pte[PRESENT_BIT];

   generate
      if (FLD_W >= FRAME_W) begin : g_slice
         assign frame = pte[OFS_W +: FRAME_W];
      end else begin : g_extend
         assign frame = {{(FRAME_W-FLD_W){1'b0}}, pte[PTE_W-1:OFS_W]};
      end
   endgenerate
endmodule

// File: rtl/pgw_walk_ctrl.sv
module pgw_walk_ctrl
   import pgw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic rsp_valid,
   input  logic rsp_present,
   output logic ready,
   output logic issue,
   output logic sel_leaf,
   output logic take_req,
   output logic take_root,
   output logic take_leaf,
   output logic take_root_fault,
   output logic done
);
   walk_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_valid) state_d = ST_L1_REQ;
         ST_L1_REQ:  state_d = ST_L1_WAIT;
         ST_L1_WAIT: if (rsp_valid) state_d = rsp_present ? ST_L2_REQ : ST_DONE;
         ST_L2_REQ:  state_d = ST_L2_WAIT;
         ST_L2_WAIT: if (rsp_valid) state_d = ST_DONE;
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign ready           = (state_q == ST_IDLE);
   assign issue           = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign sel_leaf        = (state_q == ST_L2_REQ);
   assign take_req        = ready && req_valid;
   assign take_root       = (state_q == ST_L1_WAIT) && rsp_valid && rsp_present;
   assign take_root_fault = (state_q == ST_L1_WAIT) && rsp_valid && !rsp_present;
   assign take_leaf       = (state_q == ST_L2_WAIT) && rsp_valid;
   assign done            = (state_q == ST_DONE);
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int TOP_W       = 10,
   parameter int LEAF_W      = 10,
   parameter int OFS_W       = 12,
   parameter int PA_W        = 32,
   parameter int PTE_W       = 32,
   parameter int PRESENT_BIT = 0,
   localparam int VA_W       = TOP_W + LEAF_W + OFS_W,
   localparam int FRAME_W    = PA_W - OFS_W,
   localparam int PTE_SHIFT  = clog2_u(PTE_W / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_va,
   input  logic [FRAME_W-1:0] req_root,
   output logic               mem_req_valid,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               done,
   output logic               done_fault,
   output logic [PA_W-1:0]    done_pa
);
   if (PTE_W % 8 != 0 || (1 << PTE_SHIFT) * 8 != PTE_W) begin : g_bad_pte
      $error("pgw_walker: entry width must be a power-of-two number of bytes");
   end
   if (FRAME_W < 1) begin : g_bad_pa
      $error("pgw_walker: physical address narrower than the page offset");
   end

   logic [VA_W-1:0]    va_q;
   logic [FRAME_W-1:0] root_q;
   logic [FRAME_W-1:0] leaf_tbl_q;
   logic [PA_W-1:0]    pa_q;
   logic               fault_q;

   logic [TOP_W-1:0]   top_idx;
   logic [LEAF_W-1:0]  leaf_idx;
   logic [OFS_W-1:0]   page_ofs;
   logic [PA_W-1:0]    root_entry_addr;
   logic [PA_W-1:0]    leaf_entry_addr;
   logic               pte_present;
   logic [FRAME_W-1:0] pte_frame;

   logic issue, sel_leaf, take_req, take_root, take_leaf, take_root_fault, walk_done;

   pgw_va_split #(.TOP_W(TOP_W), .LEAF_W(LEAF_W), .OFS_W(OFS_W)) u_split (
      .va(va_q), .top_idx(top_idx), .leaf_idx(leaf_idx), .page_ofs(page_ofs)
   );

   pgw_pte_addr #(.IDX_W(TOP_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W), .PTE_SHIFT(PTE_SHIFT))
   u_root_addr (
      .table_frame(root_q), .idx(top_idx), .entry_addr(root_entry_addr)
   );

   pgw_pte_addr #(.IDX_W(LEAF_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W), .PTE_SHIFT(PTE_SHIFT))
   u_leaf_addr (
      .table_frame(leaf_tbl_q), .idx(leaf_idx), .entry_addr(leaf_entry_addr)
   );

   pgw_pte_decode #(.PTE_W(PTE_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W), .PRESENT_BIT(PRESENT_BIT))
   u_decode (
      .pte(mem_rsp_data), .present(pte_present), .frame(pte_frame)
   );

   pgw_walk_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .rsp_valid(mem_rsp_valid), .rsp_present(pte_present),
      .ready(req_ready), .issue(issue), .sel_leaf(sel_leaf),
      .take_req(take_req), .take_root(take_root), .take_leaf(take_leaf),
      .take_root_fault(take_root_fault), .done(walk_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q       <= '0;
         root_q     <= '0;
         leaf_tbl_q <= '0;
         pa_q       <= '0;
         fault_q    <= 1'b0;
      end else begin
         if (take_req) begin
            va_q    <= req_va;
            root_q  <= req_root;
            pa_q    <= '0;
            fault_q <= 1'b0;
         end
         if (take_root) leaf_tbl_q <= pte_frame;
         if (take_root_fault) begin
            pa_q    <= '0;
            fault_q <= 1'b1;
         end
         if (take_leaf) begin
            pa_q    <= pte_present ? {pte_frame, page_ofs} : '0;
            fault_q <= !pte_present;
         end
      end
   end

   assign mem_req_valid = issue;
   assign mem_req_addr  = sel_leaf ? leaf_entry_addr : root_entry_addr;
   assign done          = walk_done;
   assign done_fault    = walk_done & fault_q;
   assign done_pa       = walk_done ? pa_q : '0;
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
   parameter int TOP_W     = 10,
   parameter int LEAF_W    = 10,
   parameter int OFS_W     = 12,
   parameter int PA_W      = 32,
   parameter int PTE_SHIFT = 2,
   localparam int VA_W     = TOP_W + LEAF_W + OFS_W,
   localparam int FRAME_W  = PA_W - OFS_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [VA_W-1:0]    req_va,
   input logic [FRAME_W-1:0] req_root,
   input logic               mem_req_valid,
   input logic [PA_W-1:0]    mem_req_addr,
   input logic               mem_rsp_valid,
   input logic               done,
   input logic               done_fault,
   input logic [PA_W-1:0]    done_pa
);
   logic [VA_W-1:0]    va_h;
   logic [FRAME_W-1:0] root_h;
   logic [1:0]         reads_n;
   logic [PA_W-1:0]    exp_root_addr;
   logic [OFS_W-1:0]   exp_leaf_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_h    <= '0;
         root_h  <= '0;
         reads_n <= '0;
      end else if (req_valid && req_ready) begin
         va_h    <= req_va;
         root_h  <= req_root;
         reads_n <= '0;
      end else if (mem_req_valid && reads_n != 2'd3) begin
         reads_n <= reads_n + 2'd1;
      end
   end

   assign exp_root_addr = (PA_W'(root_h) << OFS_W) |
                          (PA_W'(va_h[VA_W-1 -: TOP_W]) << PTE_SHIFT);
   assign exp_leaf_ofs  = OFS_W'(OFS_W'(va_h[OFS_W +: LEAF_W]) << PTE_SHIFT);

   // R1
   p_root_read_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && reads_n == 2'd0) |-> (mem_req_addr == exp_root_addr));
   // R2
   p_leaf_read_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && reads_n == 2'd1) |-> (mem_req_addr[OFS_W-1:0] == exp_leaf_ofs));
   // R3
   p_pa_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_pa[OFS_W-1:0] == va_h[OFS_W-1:0]));
   // R4, R5
   p_fault_no_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_pa == '0));
   // R5
   p_fault_read_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (reads_n == 2'd1 || reads_n == 2'd2));
   // R6
   p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || done) |-> !req_ready);
   // R7
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));
   // R7
   p_quiet_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!done_fault && done_pa == '0));
   // R8
   p_single_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
endmodule

bind pgw_walker pgw_walker_chk #(
   .TOP_W(TOP_W), .LEAF_W(LEAF_W), .OFS_W(OFS_W), .PA_W(PA_W), .PTE_SHIFT(PTE_SHIFT)
) u_pgw_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_va(req_va), .req_root(req_root), .mem_req_valid(mem_req_valid),
   .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done),
   .done_fault(done_fault), .done_pa(done_pa)
);

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;
   localparam int VA_W = 32;
   localparam int PA_W = 32;
   localparam int FRAME_W = 20;
   localparam logic [19:0] ROOT = 20'h00ABC;
   localparam int LEAF_BASE = 32'h40000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [31:0] req_va = '0;
   logic [19:0] req_root = '0;
   logic mem_req_valid;
   logic [31:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic done, done_fault;
   logic [31:0] done_pa;

   int n_checks = 0;
   int n_fail = 0;
   int walk_no = 0;

   always #2.5 clk = ~clk;

   pgw_walker u_pgw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_root(req_root), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
      .done_pa(done_pa)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (walk %0d)", req, act, exp, walk_no);
      end
   endtask

   function automatic bit root_present(input int t);
      return (t % 7) != 5;
   endfunction
   function automatic bit leaf_present(input int t, input int l);
      return ((t + l) % 13) != 9;
   endfunction
   function automatic logic [19:0] leaf_frame(input int t, input int l);
      return 20'((t * 1024 + l) ^ 32'h3C3C5);
   endfunction

   // memory model: entry contents derived from the address alone
   function automatic logic [31:0] mem_model(input logic [31:0] a);
      int idx;
      int t;
      idx = int'(a[11:2]);
      if (a[31:12] == ROOT)
         return {20'(LEAF_BASE + idx), 11'h2AA, root_present(idx)};
      t = int'(a[31:12]) - LEAF_BASE;
      return {leaf_frame(t, idx), 11'h155, leaf_present(t, idx)};
   endfunction

   task automatic walk(input logic [31:0] va, input int lat, input bit poke);
      int t, l, reads, cnt;
      bit pend, got;
      bit exp_fault;
      logic [31:0] exp_pa;
      t = int'(va[31:22]);
      l = int'(va[21:12]);
      exp_fault = !root_present(t) || !leaf_present(t, l);
      exp_pa = exp_fault ? 32'h0 : {leaf_frame(t, l), va[11:0]};
      walk_no++;
      @(negedge clk);
      req_valid = 1'b1;
      req_va = va;
      req_root = ROOT;
      reads = 0; pend = 0; cnt = 0; got = 0;
      for (int cyc = 0; cyc < 200 && !got; cyc++) begin
         @(negedge clk);
         if (poke) begin
            req_valid = 1'b1;
            req_va = ~va;
            req_root = ~ROOT;
            chk(req_ready == 1'b0, "R6 ready low while busy", 32'(req_ready), 32'h0);
         end else begin
            req_valid = 1'b0;
         end
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data = mem_model(mem_req_addr_q);
               pend = 0;
            end else cnt--;
         end
         if (mem_req_valid) begin
            reads++;
            if (reads == 1)
               chk(mem_req_addr == {ROOT, 12'(t * 4)}, "R1 root read address",
                   mem_req_addr, {ROOT, 12'(t * 4)});
            else
               chk(mem_req_addr == {20'(LEAF_BASE + t), 12'(l * 4)}, "R2 leaf read address",
                   mem_req_addr, {20'(LEAF_BASE + t), 12'(l * 4)});
            mem_req_addr_q = mem_req_addr;
            pend = 1;
            cnt = lat;
         end
         if (done) begin
            got = 1;
            req_valid = 1'b0;
            chk(done_fault == exp_fault, exp_fault ? "R4/R5 fault flag" : "R3 fault flag",
                32'(done_fault), 32'(exp_fault));
            chk(done_pa == exp_pa, exp_fault ? "R4/R5 zero address" : "R3 physical address",
                done_pa, exp_pa);
            if (!root_present(t))
               chk(reads == 1, "R4 single read on root fault", 32'(reads), 32'd1);
            else
               chk(reads == 2, "R5 two reads", 32'(reads), 32'd2);
         end
      end
      if (!got) chk(1'b0, "R8 walk never finished", 32'h0, 32'h1);
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R7 one-cycle done then ready",
          {30'h0, done, req_ready}, 32'h1);
   endtask

   logic [31:0] mem_req_addr_q = '0;

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R10 reset state",
          {29'h0, req_ready, done, mem_req_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R10 idle after reset",
          {30'h0, req_ready, mem_req_valid}, 32'h2);

      // R9: example address, slow memory
      walk(32'h00403004, 17, 1'b0);
      chk(32'h00403004 >> 22 == 1 && ((32'h00403004 >> 12) & 32'h3FF) == 3,
          "R9 index split", 32'h00403004, 32'h00403004);

      // sweep every root index with a varying leaf and offset
      for (int t = 0; t < 1024; t++) begin
         walk({10'(t), 10'((t * 37) % 1024), 12'((t * 291) % 4096)}, t % 5, (t % 9) == 4);
      end
      // every leaf under the first and the last root entry
      for (int l = 0; l < 1024; l++) begin
         walk({10'd0, 10'(l), 12'hFFF - 12'(l)}, l % 4, 1'b0);
         walk({10'd1023, 10'(l), 12'(l * 3)}, (l % 3) * 2, (l % 16) == 7);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule